// File: doc/BRIEF.md
# Prioritised Interrupt Acceptance Unit with Post-Enable Shadow

This unit decides, at each instruction boundary of a small in-order CPU, whether a pending interrupt request is taken. It latches requests from a set of sources into pending flags. Each source has a 3-bit priority level taken from a configuration input. The unit finds the highest-level eligible request and compares it against a current mask level. When the request wins, the unit reports the accepted source index and its level for one cycle. The pipeline then pushes state and fetches the handler. That work lies outside this block.

An enable-interrupt instruction loads the mask level. Level 0 opens every priority. Level 7 is never masked. When an enable or a return-from-interrupt instruction completes, acceptance is held off for exactly one instruction. This gives the instruction after it time to run, for example to narrow the mask again. Requests whose source is currently claimed by a DMA channel are passed over, and they stay pending. Source 0 can be switched to level-sensitive mode. In that mode its request follows the pin, so it comes back after acceptance for as long as the pin is held.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset no flag is pending, the mask level is 7, the shadow flag is clear and accept_o is 0. Only level-7 requests can then be accepted.
- R2: A rising edge on an edge-mode request line sets that source's pending flag. When the flag is accepted at a boundary, accept_o is 1 in the next cycle, vec_o holds the source index and lvl_o holds its level.
- R3: Acceptance happens only in a cycle where retire_i is 1. Pending requests are not taken while no instruction retires.
- R4: A pending source is eligible only when its level is nonzero and either its level is at or above the mask level, or its level is 7. An enable strobe loads the mask from ei_level_i, and level 0 opens levels 1 to 7.
- R5: Among eligible sources the highest level is accepted. Between equal levels the lower source index wins.
- R6: On acceptance the mask level becomes the accepted level plus one, saturating at 7. The pending flag of an edge-mode source is cleared.
- R7: If ei_i or reti_i arrives together with retire_i, that boundary accepts nothing. If the strobe arrives without retire_i, the next boundary accepts nothing. The boundary after the skipped one accepts normally.
- R8: Every boundary clears the shadow flag, whether or not anything is pending.
- R9: A pending source whose dma_claim_i bit is 1 is not accepted, and a lower eligible source may be taken in its place. The request stays pending and is accepted once the claim drops.
- R10: When level_mode_i is 1, the pending flag of source 0 follows its pin. The source is accepted again at each open boundary while the pin is high, and it is not accepted after the pin falls. In edge mode a held pin yields a single acceptance.
- R11: A new rising edge on a source in the same cycle as that source's acceptance leaves its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Interrupt request lines |
| prio_i | input | NUM_SRC*3 | Level per source, source i at bits 3i+2..3i; 0 disables |
| level_mode_i | input | 1 | Source 0 level-sensitive when 1 |
| dma_claim_i | input | NUM_SRC | Source currently consumed by a DMA channel |
| retire_i | input | 1 | An instruction retired this cycle (a boundary) |
| ei_i | input | 1 | Enable-interrupt instruction strobe |
| ei_level_i | input | 3 | Mask level carried by the enable instruction |
| reti_i | input | 1 | Return-from-interrupt strobe |
| accept_o | output | 1 | Interrupt accepted (one cycle after the boundary) |
| vec_o | output | clog2(NUM_SRC) | Accepted source index |
| lvl_o | output | 3 | Accepted level |

## Verification
Several things can coincide at one boundary. An acceptance clears a pending flag while a new edge, or the held level-mode pin, sets the same flag again. A shadow-opening strobe can also land on the very boundary it must suppress. The bench creates each case by raising the request or the strobe in the same cycle as retire_i. It judges the result from the next boundaries: a second acceptance must follow a coincident edge or a held pin, and exactly one boundary must be lost after an enable or a return. Sweeps over every mask and level pair, and over every pair of competing levels, check eligibility and selection against values the bench computes itself.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_TOP = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] lvl_t;

  function automatic lvl_t lvl_sat_inc(lvl_t l);
    return (l == lvl_t'(LVL_TOP)) ? l : l + lvl_t'(1);
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               level_mode_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pending_o
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic rise;
    assign rise = req_i[i] & ~req_q[i];
    if (i == 0) begin : g_lvl_capable
      // level mode: flag tracks the pin, so acceptance cannot retire it
      always_comb begin
        if (level_mode_i) pend_d[i] = req_i[i];
        else              pend_d[i] = (pend_q[i] & ~clr_i[i]) | rise;
      end
    end else begin : g_edge
      always_comb pend_d[i] = (pend_q[i] & ~clr_i[i]) | rise;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       pending_i,
  input  logic [NUM_SRC-1:0]       claim_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  lvl_t                     mask_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o,
  output lvl_t                     lvl_o
);
  lvl_t               lvl_a [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign lvl_a[i] = prio_i[i*LVL_W +: LVL_W];
    assign elig[i]  = pending_i[i] & ~claim_i[i] & (lvl_a[i] != '0) &
                      ((lvl_a[i] >= mask_i) | (lvl_a[i] == lvl_t'(LVL_TOP)));
  end

  // strict compare keeps the lowest index among equal levels
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!any_o || lvl_a[i] > lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/irq_shadow_ctrl.sv
module irq_shadow_ctrl
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  logic ei_i,
  input  lvl_t ei_level_i,
  input  logic reti_i,
  input  logic take_i,
  input  lvl_t take_lvl_i,
  output logic shadow_o,
  output logic inhibit_o,
  output lvl_t mask_o
);
  logic inhibit_q;
  lvl_t mask_q;
  logic opener;

  assign opener   = ei_i | reti_i;
  // a strobe that retires with its own boundary consumes that boundary
  assign shadow_o = inhibit_q | opener;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              inhibit_q <= 1'b0;
    else if (retire_i)        inhibit_q <= 1'b0;
    else if (opener)          inhibit_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= lvl_t'(LVL_TOP);
    else if (ei_i)   mask_q <= ei_level_i;
    else if (take_i) mask_q <= lvl_sat_inc(take_lvl_i);
  end

  assign inhibit_o = inhibit_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  logic                     level_mode_i,
  input  logic [NUM_SRC-1:0]       dma_claim_i,
  input  logic                     retire_i,
  input  logic                     ei_i,
  input  logic [LVL_W-1:0]         ei_level_i,
  input  logic                     reti_i,
  output logic                     accept_o,
  output logic [IDX_W-1:0]         vec_o,
  output logic [LVL_W-1:0]         lvl_o
);
  logic [NUM_SRC-1:0] pending_q;
  logic [NUM_SRC-1:0] clr;
  logic               any;
  logic [IDX_W-1:0]   sel_idx;
  lvl_t               sel_lvl;
  logic               shadow;
  logic               inhibit_q;
  lvl_t               mask_q;
  logic               take;

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .level_mode_i (level_mode_i),
    .clr_i        (clr),
    .pending_o    (pending_q)
  );

  irq_prio_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .pending_i (pending_q),
    .claim_i   (dma_claim_i),
    .prio_i    (prio_i),
    .mask_i    (mask_q),
    .any_o     (any),
    .idx_o     (sel_idx),
    .lvl_o     (sel_lvl)
  );

  irq_shadow_ctrl u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .retire_i   (retire_i),
    .ei_i       (ei_i),
    .ei_level_i (ei_level_i),
    .reti_i     (reti_i),
    .take_i     (take),
    .take_lvl_i (sel_lvl),
    .shadow_o   (shadow),
    .inhibit_o  (inhibit_q),
    .mask_o     (mask_q)
  );

  assign take = retire_i & ~shadow & any;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr[i] = take & (sel_idx == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      vec_o    <= '0;
      lvl_o    <= '0;
    end else begin
      accept_o <= take;
      if (take) begin
        vec_o <= sel_idx;
        lvl_o <= sel_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               retire_i,
  input logic               ei_i,
  input logic               reti_i,
  input logic [NUM_SRC-1:0] dma_claim_i,
  input logic               accept_o,
  input logic [IDX_W-1:0]   vec_o,
  input logic [LVL_W-1:0]   lvl_o,
  input logic               inhibit_q,
  input logic [LVL_W-1:0]   mask_q
);
  logic [NUM_SRC-1:0] claim_prev;
  lvl_t               mask_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_prev <= '0;
      mask_prev  <= lvl_t'(LVL_TOP);
    end else begin
      claim_prev <= dma_claim_i;
      mask_prev  <= mask_q;
    end
  end

  p_only_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(retire_i));

  p_shadow_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && (ei_i || reti_i || inhibit_q)) |=> !accept_o);

  p_boundary_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> !inhibit_q);

  p_mask_raised_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (mask_q == ((lvl_o == lvl_t'(LVL_TOP)) ? lvl_o : lvl_o + lvl_t'(1))));

  p_level_allowed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ((lvl_o != '0) && ((lvl_o >= mask_prev) || (lvl_o == lvl_t'(LVL_TOP)))));

  p_claimed_skipped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !claim_prev[vec_o]);
endmodule

bind irq_accept_unit irq_accept_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .retire_i    (retire_i),
  .ei_i        (ei_i),
  .reti_i      (reti_i),
  .dma_claim_i (dma_claim_i),
  .accept_o    (accept_o),
  .vec_o       (vec_o),
  .lvl_o       (lvl_o),
  .inhibit_q   (inhibit_q),
  .mask_q      (mask_q)
);

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic [NS*3-1:0] prio = '0;
  logic          lmode = 1'b0;
  logic [NS-1:0] claim = '0;
  logic          retire = 1'b0;
  logic          ei = 1'b0;
  logic [2:0]    ei_lvl = '0;
  logic          reti = 1'b0;
  logic          acc;
  logic [2:0]    vec;
  logic [2:0]    lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int last_acc, last_vec, last_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_unit #(.NUM_SRC(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio),
    .level_mode_i(lmode), .dma_claim_i(claim), .retire_i(retire),
    .ei_i(ei), .ei_level_i(ei_lvl), .reti_i(reti),
    .accept_o(acc), .vec_o(vec), .lvl_o(lvl)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic capture();
    last_acc = int'(acc);
    last_vec = int'(vec);
    last_lvl = int'(lvl);
  endtask

  task automatic set_prio(input int idx, input int l);
    prio[idx*3 +: 3] = 3'(l);
  endtask

  task automatic pulse_req(input int idx);
    req[idx] = 1'b1; tick(); req[idx] = 1'b0; tick();
  endtask

  task automatic boundary();
    retire = 1'b1; tick(); retire = 1'b0; capture();
  endtask

  task automatic do_ei(input int l, input bit with_retire);
    ei = 1'b1; ei_lvl = 3'(l); retire = with_retire; tick();
    ei = 1'b0; retire = 1'b0; capture();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(acc == 1'b0, "R1", int'(acc), 0);
    boundary();
    chk(last_acc == 0, "R1", last_acc, 0);
    set_prio(2, 6); pulse_req(2); boundary();
    chk(last_acc == 0, "R1", last_acc, 0);
    set_prio(1, 7); pulse_req(1); boundary();
    chk(last_acc == 1 && last_vec == 1 && last_lvl == 7, "R1", last_vec, 1);
    do_ei(0, 1); boundary();
    chk(last_acc == 1 && last_vec == 2, "R1", last_vec, 2);
    prio = '0;

    // R4/R2/R6 sweep of mask versus level
    for (int m = 0; m < 8; m++) begin
      for (int l = 1; l < 8; l++) begin
        bit exp;
        prio = '0; set_prio(1, l);
        do_ei(m, 1);
        pulse_req(1);
        boundary();
        exp = (l >= m) || (l == 7);
        chk(last_acc == int'(exp), "R4", last_acc, int'(exp));
        if (last_acc == 1) begin
          chk(last_vec == 1 && last_lvl == l, "R2", last_lvl, l);
          pulse_req(1);
          boundary();
          chk(last_acc == int'(l == 7), "R6", last_acc, int'(l == 7));
        end
        do_ei(0, 1);
        boundary();
      end
    end

    // R5 sweep of competing levels, src 2 against src 5
    for (int la = 1; la < 8; la++) begin
      for (int lb = 1; lb < 8; lb++) begin
        int ev, el, ov;
        prio = '0; set_prio(2, la); set_prio(5, lb);
        do_ei(0, 1);
        req[2] = 1'b1; req[5] = 1'b1; tick(); req = '0; tick();
        boundary();
        ev = (lb > la) ? 5 : 2;
        el = (lb > la) ? lb : la;
        ov = (ev == 5) ? 2 : 5;
        chk(last_acc == 1 && last_vec == ev && last_lvl == el, "R5", last_vec, ev);
        do_ei(0, 1);
        boundary();
        chk(last_acc == 1 && last_vec == ov, "R5", last_vec, ov);
      end
    end

    // R3 no acceptance without a boundary
    prio = '0; set_prio(3, 4);
    do_ei(0, 1); pulse_req(3);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(acc == 1'b0, "R3", int'(acc), 0);
    end
    boundary();
    chk(last_acc == 1 && last_vec == 3, "R3", last_acc, 1);

    // R7 strobe retiring with its boundary
    pulse_req(3);
    do_ei(0, 1);
    chk(last_acc == 0, "R7", last_acc, 0);
    boundary();
    chk(last_acc == 1 && last_vec == 3, "R7", last_acc, 1);
    // R7 strobe ahead of its boundary
    pulse_req(3);
    do_ei(0, 0);
    boundary();
    chk(last_acc == 0, "R7", last_acc, 0);
    boundary();
    chk(last_acc == 1, "R7", last_acc, 1);
    // R7 return strobe
    do_ei(0, 1);
    pulse_req(3);
    reti = 1'b1; retire = 1'b1; tick(); reti = 1'b0; retire = 1'b0; capture();
    chk(last_acc == 0, "R7", last_acc, 0);
    boundary();
    chk(last_acc == 1, "R7", last_acc, 1);

    // R8 shadow cleared by an empty boundary
    do_ei(0, 0);
    boundary();
    chk(last_acc == 0, "R8", last_acc, 0);
    pulse_req(3);
    boundary();
    chk(last_acc == 1 && last_vec == 3, "R8", last_acc, 1);

    // R9 DMA claim
    prio = '0; set_prio(4, 5); set_prio(6, 2);
    do_ei(0, 1);
    claim[4] = 1'b1;
    pulse_req(4);
    boundary();
    chk(last_acc == 0, "R9", last_acc, 0);
    pulse_req(6);
    boundary();
    chk(last_acc == 1 && last_vec == 6, "R9", last_vec, 6);
    claim[4] = 1'b0; tick();
    boundary();
    chk(last_acc == 1 && last_vec == 4 && last_lvl == 5, "R9", last_vec, 4);

    // R10 level-sensitive source 0
    prio = '0; set_prio(0, 3);
    lmode = 1'b1;
    req[0] = 1'b1; tick();
    do_ei(0, 1); boundary();
    chk(last_acc == 1 && last_vec == 0 && last_lvl == 3, "R10", last_acc, 1);
    do_ei(0, 1); boundary();
    chk(last_acc == 1 && last_vec == 0, "R10", last_acc, 1);
    req[0] = 1'b0; tick(); tick();
    do_ei(0, 1); boundary();
    chk(last_acc == 0, "R10", last_acc, 0);
    lmode = 1'b0; tick();
    req[0] = 1'b1; tick();
    do_ei(0, 1); boundary();
    chk(last_acc == 1 && last_vec == 0, "R10", last_acc, 1);
    do_ei(0, 1); boundary();
    chk(last_acc == 0, "R10", last_acc, 0);
    req[0] = 1'b0; tick();

    // R11 new edge during the accepting boundary
    prio = '0; set_prio(3, 4);
    do_ei(0, 1);
    pulse_req(3);
    req[3] = 1'b1; retire = 1'b1; tick(); req[3] = 1'b0; retire = 1'b0; capture();
    chk(last_acc == 1 && last_vec == 3, "R11", last_acc, 1);
    do_ei(0, 1); boundary();
    chk(last_acc == 1 && last_vec == 3, "R11", last_acc, 1);
    do_ei(0, 1); boundary();
    chk(last_acc == 0, "R11", last_acc, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule